// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block sits beside the fetch stage of a small in-order core and runs two nested loops with no branch instructions in the loop body. Each loop has its own register set: a start address, an end address (the address of the last instruction in the body) and an iteration count. Setup instructions load these registers one at a time through a register-write port. Every cycle the core shows the block the address of the instruction going through. When that address equals a loop's end address and the loop's count is not zero, the block uses up one iteration. If more iterations remain, it tells fetch to jump back to the loop's start.

A count of zero means the loop is switched off. Instructions in its address range then run as ordinary straight-line code, so writing the count is the step that starts a loop. The block does not check whether software followed the setup rules. It does not check the order of the register writes or branches into a loop body. It acts on whatever values the registers hold at the time. Set 0 is the inner loop. When both loops end at the same address, set 0 is resolved first, and set 1 is considered in the same cycle only if set 0 does not jump back.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset every start, end and count register reads back as zero, and `redirect_o` stays low.
- R2: A write with `we_i` high loads the register picked by `wsel_i` (loop index) and `wreg_i` (2'b00 start, 2'b01 end, 2'b10 count). The new value reads back from the next cycle. Start and end values are stored with bits [1:0] cleared. The code 2'b11 changes no register.
- R3: A loop whose count is zero never raises a redirect, and its count stays zero while no write to it occurs.
- R4: When `pc_valid_i` is high, `pc_i` equals a loop's end address and that loop's count is greater than 1, then `redirect_o` is high in the same cycle. `target_o` then equals that loop's start address, and the count is one lower from the next cycle.
- R5: When the count of a matching loop is exactly 1, no redirect comes from that loop and its count becomes 0 in the next cycle.
- R6: No count changes and no redirect is raised when `pc_valid_i` is low, or when `pc_i` matches no loop end address.
- R7: When both loops match the same address and loop 0 has a count greater than 1, only loop 0 acts: the redirect targets loop 0's start and loop 1's count is unchanged.
- R8: When both loops match and loop 0's count is 1 or 0, loop 1 is handled in the same cycle. Loop 1 redirects to its own start if its count is greater than 1, and its count decrements.
- R9: A write to a count register in the same cycle as that loop's decrement wins: the written value is what reads back next cycle.
- R10: No setup rule is enforced. Only the end address and the count decide whether a loop acts, so a start address above the end address still serves as the redirect target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Loop register write enable |
| wsel_i | input | 1 | Loop index for the write (0 inner, 1 outer) |
| wreg_i | input | 2 | Register select: 00 start, 01 end, 10 count, 11 none |
| wdata_i | input | 32 | Write data |
| pc_valid_i | input | 1 | `pc_i` holds a valid instruction address this cycle |
| pc_i | input | 32 | Current instruction address |
| redirect_o | output | 1 | Fetch must jump to `target_o` |
| target_o | output | 32 | Loop start address to fetch next |
| start_o | output | 2x32 | Start address readback, one per loop |
| end_o | output | 32 x 2 | End address readback, one per loop |
| count_o | output | 32 x 2 | Iteration count readback, one per loop |

## Verification
The checker module watches five things on every cycle:
- A redirect occurs only at a matching end address with a count above one.
- A redirect from the inner loop carries the inner loop's start as its target.
- The inner count decrements.
- Counts hold while no valid address is present, and a zero count stays zero.
- A count write wins over a decrement.

Other behaviour can only be shown by the directed scenarios:
- The shared-end cascade, where the outer loop takes over once the inner loop has used up its iterations.
- The clearing of the low address bits.
- The ignored register code.
- A start address above the end address still serving as the target.
- The full run of one loop down to its fall-through.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  typedef enum logic [1:0] {
    LREG_START = 2'b00,
    LREG_END   = 2'b01,
    LREG_COUNT = 2'b10,
    LREG_NONE  = 2'b11
  } lreg_e;
endpackage

// File: rtl/hwloop_regs.sv
module hwloop_regs #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int AB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_start_i,
  input  logic          wr_end_i,
  input  logic          wr_count_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          dec_i,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] end_o,
  output logic [CW-1:0] count_o
);
  logic [AW-1:0] start_q, end_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
    end else begin
      if (wr_start_i) start_q <= {wdata_i[AW-1:AB], {AB{1'b0}}};
      if (wr_end_i)   end_q   <= {wdata_i[AW-1:AB], {AB{1'b0}}};
    end
  end

  // write takes priority over loop decrement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         count_q <= '0;
    else if (wr_count_i) count_q <= wdata_i[CW-1:0];
    else if (dec_i)      count_q <= count_q - CW'(1);
  end

  assign start_o = start_q;
  assign end_o   = end_q;
  assign count_o = count_q;
endmodule

// File: rtl/hwloop_match.sv
module hwloop_match #(
  parameter int NL = 2,
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic                   pc_valid_i,
  input  logic [AW-1:0]          pc_i,
  input  logic [NL-1:0][AW-1:0]  start_i,
  input  logic [NL-1:0][AW-1:0]  end_i,
  input  logic [NL-1:0][CW-1:0]  count_i,
  output logic [NL-1:0]          dec_o,
  output logic                   redirect_o,
  output logic [AW-1:0]          target_o
);
  logic [NL-1:0] hit;
  logic [NL-1:0] more;

  for (genvar g = 0; g < NL; g++) begin : g_cmp
    assign hit[g]  = pc_valid_i && (count_i[g] != '0) && (pc_i == end_i[g]);
    assign more[g] = count_i[g] > CW'(1);
  end

  // lower index = inner loop; outer loop is seen only while inner ones fall through
  always_comb begin
    logic pass;
    pass       = 1'b1;
    dec_o      = '0;
    redirect_o = 1'b0;
    target_o   = '0;
    for (int i = 0; i < NL; i++) begin
      if (hit[i] && pass) begin
        dec_o[i] = 1'b1;
        if (more[i]) begin
          redirect_o = 1'b1;
          target_o   = start_i[i];
          pass       = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
  parameter int NL = 2,
  parameter int AW = 32,
  parameter int CW = 32,
  parameter int AB = 2,
  localparam int SW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [SW-1:0]          wsel_i,
  input  logic [1:0]             wreg_i,
  input  logic [AW-1:0]          wdata_i,
  input  logic                   pc_valid_i,
  input  logic [AW-1:0]          pc_i,
  output logic                   redirect_o,
  output logic [AW-1:0]          target_o,
  output logic [NL-1:0][AW-1:0]  start_o,
  output logic [NL-1:0][AW-1:0]  end_o,
  output logic [NL-1:0][CW-1:0]  count_o
);
  import hwloop_pkg::*;

  logic [NL-1:0] wr_start, wr_end, wr_count, dec;

  for (genvar g = 0; g < NL; g++) begin : g_loop
    logic sel;
    assign sel         = we_i && (wsel_i == SW'(g));
    assign wr_start[g] = sel && (wreg_i == LREG_START);
    assign wr_end[g]   = sel && (wreg_i == LREG_END);
    assign wr_count[g] = sel && (wreg_i == LREG_COUNT);

    hwloop_regs #(.AW(AW), .CW(CW), .AB(AB)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_start_i (wr_start[g]),
      .wr_end_i   (wr_end[g]),
      .wr_count_i (wr_count[g]),
      .wdata_i    (wdata_i),
      .dec_i      (dec[g]),
      .start_o    (start_o[g]),
      .end_o      (end_o[g]),
      .count_o    (count_o[g])
    );
  end

  hwloop_match #(.NL(NL), .AW(AW), .CW(CW)) u_match (
    .pc_valid_i (pc_valid_i),
    .pc_i       (pc_i),
    .start_i    (start_o),
    .end_i      (end_o),
    .count_i    (count_o),
    .dec_o      (dec),
    .redirect_o (redirect_o),
    .target_o   (target_o)
  );
endmodule

// File: rtl/hwloop_ctrl_sva.sv
module hwloop_ctrl_sva #(
  parameter int NL = 2,
  parameter int AW = 32,
  parameter int CW = 32,
  localparam int SW = (NL > 1) ? $clog2(NL) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   we_i,
  input logic [SW-1:0]          wsel_i,
  input logic [1:0]             wreg_i,
  input logic [AW-1:0]          wdata_i,
  input logic                   pc_valid_i,
  input logic [AW-1:0]          pc_i,
  input logic                   redirect_o,
  input logic [AW-1:0]          target_o,
  input logic [NL-1:0][AW-1:0]  start_o,
  input logic [NL-1:0][AW-1:0]  end_o,
  input logic [NL-1:0][CW-1:0]  count_o
);
  logic any_live;
  always_comb begin
    any_live = 1'b0;
    for (int i = 0; i < NL; i++)
      if (pc_i == end_o[i] && count_o[i] > CW'(1)) any_live = 1'b1;
  end

  p_redirect_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (pc_valid_i && any_live));

  p_inner_target_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_valid_i && pc_i == end_o[0] && count_o[0] > CW'(1)) |-> (redirect_o && target_o == start_o[0]));

  p_inner_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && pc_valid_i && pc_i == end_o[0] && count_o[0] != '0) |=> (count_o[0] == $past(count_o[0]) - CW'(1)));

  for (genvar g = 0; g < NL; g++) begin : g_chk
    p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!we_i && !pc_valid_i) |=> (count_o[g] == $past(count_o[g])));

    p_zero_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!we_i && count_o[g] == '0) |=> (count_o[g] == '0));

    p_write_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && wsel_i == SW'(g) && wreg_i == 2'b10) |=> (count_o[g] == $past(wdata_i[CW-1:0])));
  end
endmodule

bind hwloop_ctrl hwloop_ctrl_sva #(.NL(NL), .AW(AW), .CW(CW)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .wsel_i     (wsel_i),
  .wreg_i     (wreg_i),
  .wdata_i    (wdata_i),
  .pc_valid_i (pc_valid_i),
  .pc_i       (pc_i),
  .redirect_o (redirect_o),
  .target_o   (target_o),
  .start_o    (start_o),
  .end_o      (end_o),
  .count_o    (count_o)
);

// File: tb/hwloop_ctrl_tb_top.sv
module hwloop_ctrl_tb_top;
  localparam int NL = 2;
  localparam int AW = 32;
  localparam int CW = 32;

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  we_i = 1'b0;
  logic [0:0]            wsel_i = '0;
  logic [1:0]            wreg_i = '0;
  logic [AW-1:0]         wdata_i = '0;
  logic                  pc_valid_i = 1'b0;
  logic [AW-1:0]         pc_i = '0;
  logic                  redirect_o;
  logic [AW-1:0]         target_o;
  logic [NL-1:0][AW-1:0] start_o, end_o;
  logic [NL-1:0][CW-1:0] count_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hwloop_ctrl #(.NL(NL), .AW(AW), .CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .wsel_i(wsel_i), .wreg_i(wreg_i),
    .wdata_i(wdata_i), .pc_valid_i(pc_valid_i), .pc_i(pc_i),
    .redirect_o(redirect_o), .target_o(target_o),
    .start_o(start_o), .end_o(end_o), .count_o(count_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // at a negedge: drive write, wait one cycle
  task automatic wr(input int idx, input logic [1:0] r, input logic [31:0] d);
    we_i = 1'b1; wsel_i = idx[0:0]; wreg_i = r; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  // present one address, check comb outputs, advance one cycle
  task automatic step(input logic v, input logic [31:0] pc, input logic exp_r,
                      input logic [31:0] exp_t, input string req);
    pc_valid_i = v; pc_i = pc;
    #1;
    chk({req, " redirect"}, {31'd0, redirect_o}, {31'd0, exp_r});
    if (exp_r) chk({req, " target"}, target_o, exp_t);
    @(negedge clk);
    pc_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < NL; i++) begin
      chk("R1 start", start_o[i], '0);
      chk("R1 end", end_o[i], '0);
      chk("R1 count", count_o[i], '0);
    end
    step(1'b1, 32'h0, 1'b0, '0, "R1/R3 zero count at end");
    chk("R3 count stays zero", count_o[0], '0);
  endtask

  task automatic t_write;
    wr(0, 2'b00, 32'h0000_1003);
    chk("R2 start align", start_o[0], 32'h0000_1000);
    wr(1, 2'b01, 32'h0000_2012);
    chk("R2 end align", end_o[1], 32'h0000_2010);
    wr(1, 2'b10, 32'd7);
    chk("R2 count1", count_o[1], 32'd7);
    chk("R2 count0 untouched", count_o[0], '0);
    wr(0, 2'b11, 32'hFFFF_FFFF);
    chk("R2 code11 start", start_o[0], 32'h0000_1000);
    chk("R2 code11 end", end_o[0], '0);
    chk("R2 code11 count", count_o[0], '0);
    wr(1, 2'b10, 32'd0);
  endtask

  task automatic t_single;
    wr(0, 2'b00, 32'h100);
    wr(0, 2'b01, 32'h10C);
    wr(0, 2'b10, 32'd3);
    step(1'b1, 32'h108, 1'b0, '0, "R6 non-end pc");
    chk("R6 count after non-end", count_o[0], 32'd3);
    step(1'b0, 32'h10C, 1'b0, '0, "R6 invalid pc");
    chk("R6 count after invalid", count_o[0], 32'd3);
    step(1'b1, 32'h10C, 1'b1, 32'h100, "R4 iter1");
    chk("R4 dec 3->2", count_o[0], 32'd2);
    step(1'b1, 32'h10C, 1'b1, 32'h100, "R4 iter2");
    chk("R4 dec 2->1", count_o[0], 32'd1);
    step(1'b1, 32'h10C, 1'b0, '0, "R5 last");
    chk("R5 dec 1->0", count_o[0], 32'd0);
    step(1'b1, 32'h10C, 1'b0, '0, "R3 disabled");
    chk("R3 count stays 0", count_o[0], 32'd0);
  endtask

  task automatic t_nested;
    wr(0, 2'b00, 32'h200);
    wr(0, 2'b01, 32'h20C);
    wr(1, 2'b00, 32'h1F0);
    wr(1, 2'b01, 32'h20C);
    wr(1, 2'b10, 32'd2);
    wr(0, 2'b10, 32'd2);
    step(1'b1, 32'h20C, 1'b1, 32'h200, "R7 inner first");
    chk("R7 inner dec", count_o[0], 32'd1);
    chk("R7 outer held", count_o[1], 32'd2);
    step(1'b1, 32'h20C, 1'b1, 32'h1F0, "R8 outer takes over");
    chk("R8 inner to 0", count_o[0], 32'd0);
    chk("R8 outer dec", count_o[1], 32'd1);
    step(1'b1, 32'h20C, 1'b0, '0, "R8 outer last");
    chk("R8 outer to 0", count_o[1], 32'd0);
  endtask

  task automatic t_wr_prio;
    wr(0, 2'b01, 32'h300);
    wr(0, 2'b10, 32'd5);
    we_i = 1'b1; wsel_i = 1'b0; wreg_i = 2'b10; wdata_i = 32'd9;
    step(1'b1, 32'h300, 1'b1, 32'h200, "R9 redirect with write");
    we_i = 1'b0;
    chk("R9 write wins", count_o[0], 32'd9);
    wr(0, 2'b10, 32'd0);
  endtask

  task automatic t_no_rules;
    wr(0, 2'b00, 32'h500);
    wr(0, 2'b01, 32'h400);
    wr(0, 2'b10, 32'd2);
    step(1'b1, 32'h400, 1'b1, 32'h500, "R10 start above end");
    chk("R10 dec", count_o[0], 32'd1);
    wr(0, 2'b10, 32'd0);
    wr(1, 2'b00, 32'h5F0);
    wr(1, 2'b01, 32'h600);
    wr(1, 2'b10, 32'd3);
    step(1'b1, 32'h600, 1'b1, 32'h5F0, "R4 outer alone");
    chk("R4 outer dec", count_o[1], 32'd2);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_single();
    t_nested();
    t_wr_prio();
    t_no_rules();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule